// File: doc/BRIEF.md
# Memory-clock-change handshake watchdog

The block confirms that a memory clock change handshake finishes in time. A single-cycle start request begins one check. The block first removes any force override that an earlier check left in place. It then writes a debug select index to the status source and samples the returned status word once per microsecond tick. The check passes when the ready bit appears in a sample. It fails when that bit has not appeared after a fixed number of ticks.

A pass that needed more ticks than expected still counts as a pass, but it also raises a late flag and reports the tick count. A failure drives a force pair that allows the clock change anyway. That force stays in place until the next check begins. Across all checks the block keeps the longest wait it has seen without completion, which shows how close the system has come to the limit.

Top module: `pstate_watchdog`

## Requirements
- R1: After reset, every output is 0, including the override pair and the maximum-wait value.
- R2: `start_i` is accepted only while `busy_o` is 0. A start pulse that arrives during a check has no effect on that check's index write or its reported tick count.
- R3: Each check writes the debug index exactly once, as a one-cycle `dbg_idx_we_o` pulse before the first sample. The index is 0x7 when `rev_sel_i` is 0 and 0xB when it is 1.
- R4: The status word is sampled once every TICK_DIV clock cycles. Sample number k (counting from 0) is taken TICK_DIV*(k+1) cycles after the cycle in which `dbg_idx_we_o` is high.
- R5: A sample with bit 30 set ends the check with `pass_o`=1. `wait_ticks_o` gives the index of that sample, and `result_word_o` gives the word that was sampled.
- R6: `late_o` is 1 on a pass whose sample index is greater than 40, and 0 otherwise.
- R7: If none of 200 samples (indices 0 to 199) has bit 30 set, the check ends with `pass_o`=0, `wait_ticks_o`=199 and `result_word_o` equal to the last sample.
- R8: A failed check sets `force_en_o` and `force_val_o` to 1. Both stay at 1 while the block is idle.
- R9: The next check clears both force outputs before its index write.
- R10: `max_wait_o` rises to the index of any sample without completion that is larger than its current value, and never falls.
- R11: `done_o` is a one-cycle pulse at the end of each check. `pass_o`, `late_o`, `wait_ticks_o` and `result_word_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a check (single-cycle pulse) |
| rev_sel_i | input | 1 | Selects the alternate debug index |
| status_i | input | DATA_W | Status word returned by the debug source |
| dbg_idx_o | output | IDX_W | Debug select index |
| dbg_idx_we_o | output | 1 | Write strobe for the debug index |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle end-of-check pulse |
| pass_o | output | 1 | The last check saw the ready bit |
| late_o | output | 1 | The last pass exceeded the expected tick count |
| wait_ticks_o | output | CNT_W | Sample index at which the last check ended |
| result_word_o | output | DATA_W | Status word from the final sample |
| max_wait_o | output | CNT_W | Largest index of a sample without completion |
| force_en_o | output | 1 | Force override enable |
| force_val_o | output | 1 | Force override value |

## Verification
An error in the tick divider or in the sample counter moves the sample index by at least one. `wait_ticks_o` therefore shows it on the very next pass, and the late flag flips at the 40/41 boundary. A lost or stuck override record shows at the force pins. The pins either fail to go high right after a timeout, or they are still high at the index write of the following check. A maximum register that updates on the wrong samples drifts away from the tracked value within one sweep step.

// File: rtl/pstate_wd_pkg.sv
package pstate_wd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SELECT,
    ST_POLL
  } wd_state_e;
endpackage

// File: rtl/pstate_tick_gen.sv
module pstate_tick_gen #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/pstate_max_track.sv
module pstate_max_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] max_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      max_o <= '0;
    end else if (upd && (cur > max_o)) begin
      max_o <= cur;
    end
  end
endmodule

// File: rtl/pstate_force_ovr.sv
module pstate_force_ovr (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic en_o,
  output logic val_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      en_o  <= 1'b0;
      val_o <= 1'b0;
    end else if (set) begin
      en_o  <= 1'b1;
      val_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pstate_watchdog.sv
module pstate_watchdog #(
  parameter int TICK_DIV   = 200,
  parameter int MAX_TICKS  = 200,
  parameter int LATE_TICKS = 40,
  parameter int READY_BIT  = 30,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter logic [IDX_W-1:0] IDX_BASE = 'h7,
  parameter logic [IDX_W-1:0] IDX_ALT  = 'hB,
  localparam int CNT_W = $clog2(MAX_TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rev_sel_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [IDX_W-1:0]  dbg_idx_o,
  output logic              dbg_idx_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              late_o,
  output logic [CNT_W-1:0]  wait_ticks_o,
  output logic [DATA_W-1:0] result_word_o,
  output logic [CNT_W-1:0]  max_wait_o,
  output logic              force_en_o,
  output logic              force_val_o
);
  import pstate_wd_pkg::*;

  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(MAX_TICKS - 1);
  localparam logic [CNT_W-1:0] LATE_C = CNT_W'(LATE_TICKS);

  wd_state_e        state_q;
  logic [CNT_W-1:0] ticks_q;
  logic             tick;
  logic             ready;
  logic             miss;
  logic             expire;

  assign ready  = status_i[READY_BIT];
  assign miss   = (state_q == ST_POLL) && tick && !ready;
  assign expire = miss && (ticks_q == LAST_C);

  pstate_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (state_q == ST_SELECT),
    .run     (state_q == ST_POLL),
    .tick    (tick)
  );

  pstate_max_track #(.CNT_W(CNT_W)) u_max (
    .clk   (clk),
    .rst   (rst),
    .upd   (miss),
    .cur   (ticks_q),
    .max_o (max_wait_o)
  );

  pstate_force_ovr u_ovr (
    .clk   (clk),
    .rst   (rst),
    .set   (expire),
    .clr   (state_q == ST_CLEAR),
    .en_o  (force_en_o),
    .val_o (force_val_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      ticks_q       <= '0;
      dbg_idx_o     <= '0;
      dbg_idx_we_o  <= 1'b0;
      busy_o        <= 1'b0;
      done_o        <= 1'b0;
      pass_o        <= 1'b0;
      late_o        <= 1'b0;
      wait_ticks_o  <= '0;
      result_word_o <= '0;
    end else begin
      done_o       <= 1'b0;
      dbg_idx_we_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q       <= ST_CLEAR;
            busy_o        <= 1'b1;
            pass_o        <= 1'b0;
            late_o        <= 1'b0;
            wait_ticks_o  <= '0;
            result_word_o <= '0;
          end
        end
        ST_CLEAR: state_q <= ST_SELECT;
        ST_SELECT: begin
          dbg_idx_o    <= rev_sel_i ? IDX_ALT : IDX_BASE;
          dbg_idx_we_o <= 1'b1;
          ticks_q      <= '0;
          state_q      <= ST_POLL;
        end
        ST_POLL: begin
          if (tick) begin
            if (ready || (ticks_q == LAST_C)) begin
              done_o        <= 1'b1;
              pass_o        <= ready;
              late_o        <= ready && (ticks_q > LATE_C);
              wait_ticks_o  <= ticks_q;
              result_word_o <= status_i;
              busy_o        <= 1'b0;
              state_q       <= ST_IDLE;
            end else begin
              ticks_q <= ticks_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pstate_watchdog_chk.sv
module pstate_watchdog_chk #(
  parameter int MAX_TICKS  = 200,
  parameter int READY_BIT  = 30,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter logic [IDX_W-1:0] IDX_BASE = 'h7,
  parameter logic [IDX_W-1:0] IDX_ALT  = 'hB,
  localparam int CNT_W = $clog2(MAX_TICKS)
) (
  input logic              clk,
  input logic              rst,
  input logic              rev_sel_i,
  input logic [DATA_W-1:0] status_i,
  input logic [IDX_W-1:0]  dbg_idx_o,
  input logic              dbg_idx_we_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              late_o,
  input logic [CNT_W-1:0]  max_wait_o,
  input logic              force_en_o,
  input logic              force_val_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(MAX_TICKS - 1);

  AST_IDX_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
    dbg_idx_we_o |-> busy_o); // R3
  AST_IDX_VALUE: assert property (@(posedge clk) disable iff (rst)
    dbg_idx_we_o |-> (dbg_idx_o == ($past(rev_sel_i) ? IDX_ALT : IDX_BASE))); // R3
  AST_PASS_SAW_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) && pass_o |-> $past(status_i[READY_BIT])); // R5
  AST_LATE_ONLY_PASS: assert property (@(posedge clk) disable iff (rst)
    late_o |-> pass_o); // R6
  AST_FAIL_FORCES: assert property (@(posedge clk) disable iff (rst)
    done_o && !pass_o |-> force_en_o && force_val_o); // R8
  AST_FORCE_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !$past(busy_o) |-> $stable(force_en_o)); // R8
  AST_FORCE_OFF_AT_IDX: assert property (@(posedge clk) disable iff (rst)
    dbg_idx_we_o |-> !force_en_o && !force_val_o); // R9
  AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    max_wait_o >= $past(max_wait_o)); // R10
  AST_MAX_BOUND: assert property (@(posedge clk) disable iff (rst)
    max_wait_o <= LAST_C); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R11
endmodule

bind pstate_watchdog pstate_watchdog_chk #(
  .MAX_TICKS (MAX_TICKS),
  .READY_BIT (READY_BIT),
  .DATA_W    (DATA_W),
  .IDX_W     (IDX_W),
  .IDX_BASE  (IDX_BASE),
  .IDX_ALT   (IDX_ALT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rev_sel_i    (rev_sel_i),
  .status_i     (status_i),
  .dbg_idx_o    (dbg_idx_o),
  .dbg_idx_we_o (dbg_idx_we_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .late_o       (late_o),
  .max_wait_o   (max_wait_o),
  .force_en_o   (force_en_o),
  .force_val_o  (force_val_o)
);

// File: tb/pstate_watchdog_tb.sv
`timescale 1ns/1ps
module pstate_watchdog_tb;
  localparam int DIV = 4;
  localparam int MAXT = 200;
  localparam int CW = $clog2(MAXT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic rev_sel_i = 1'b0;
  logic [31:0] status_i = '0;
  logic [3:0] dbg_idx_o;
  logic dbg_idx_we_o, busy_o, done_o, pass_o, late_o, force_en_o, force_val_o;
  logic [CW-1:0] wait_ticks_o, max_wait_o;
  logic [31:0] result_word_o;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int exp_max = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pstate_watchdog #(.TICK_DIV(DIV), .MAX_TICKS(MAXT)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .rev_sel_i(rev_sel_i),
    .status_i(status_i), .dbg_idx_o(dbg_idx_o), .dbg_idx_we_o(dbg_idx_we_o),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .late_o(late_o),
    .wait_ticks_o(wait_ticks_o), .result_word_o(result_word_o),
    .max_wait_o(max_wait_o), .force_en_o(force_en_o), .force_val_o(force_val_o)
  );

  always @(negedge clk) if (dbg_idx_we_o) we_cnt++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_we();
    for (int n = 0; n < 20 && !dbg_idx_we_o; n++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int n = 0; n < DIV * MAXT + 50 && !done_o; n++) @(negedge clk);
  endtask

  // one check; k < 0 means the ready bit never appears
  task automatic run_one(input int k, input bit rev, input bit poke);
    logic [31:0] pat;
    int we0;
    pat = 32'h0000_0A00 | 32'(k & 8'hFF);
    we0 = we_cnt;
    @(negedge clk);
    rev_sel_i = rev;
    status_i = pat;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_we();
    chk("R3 index value", dbg_idx_o, rev ? 4'hB : 4'h7);
    chk("R9 force cleared before index", {force_en_o, force_val_o}, 2'b00);
    if (k >= 0) begin
      if (poke) begin
        repeat (2) @(posedge clk);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (DIV * k - 3) @(posedge clk);
      end else begin
        repeat (DIV * k) @(posedge clk);
      end
      @(negedge clk) status_i = pat | 32'h4000_0000;
    end
    wait_done();
    chk("R11 done pulse seen", done_o, 1'b1);
    chk("R2 single index write", we_cnt - we0, 1);
    if (k >= 0) begin
      chk("R5 pass", pass_o, 1'b1);
      chk("R4 R5 tick index", wait_ticks_o, k);
      chk("R5 result word", result_word_o, pat | 32'h4000_0000);
      chk("R6 late flag", late_o, (k > 40));
      if (k - 1 > exp_max) exp_max = k - 1;
    end else begin
      chk("R7 fail", pass_o, 1'b0);
      chk("R7 tick index", wait_ticks_o, MAXT - 1);
      chk("R7 result word", result_word_o, pat);
      chk("R6 no late on fail", late_o, 1'b0);
      chk("R8 force set", {force_en_o, force_val_o}, 2'b11);
      exp_max = MAXT - 1;
    end
    chk("R10 max wait", max_wait_o, exp_max);
    @(negedge clk);
    chk("R11 done drops", done_o, 1'b0);
    status_i = 32'h0;
    repeat (3) @(negedge clk);
    chk("R11 pass held", pass_o, (k >= 0));
    chk("R11 ticks held", wait_ticks_o, (k >= 0) ? k : MAXT - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", {dbg_idx_o, dbg_idx_we_o, busy_o, done_o, pass_o, late_o,
        force_en_o, force_val_o}, '0);
    chk("R1 reset words", {wait_ticks_o, max_wait_o, result_word_o}, '0);
    for (int k = 0; k < MAXT; k++) run_one(k, k[0], 1'b0);
    run_one(-1, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R8 force sticky while idle", {force_en_o, force_val_o}, 2'b11);
    run_one(5, 1'b1, 1'b0);
    chk("R9 force stays off after pass", {force_en_o, force_val_o}, 2'b00);
    run_one(50, 1'b0, 1'b1);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule